// File: doc/BRIEF.md
# Cascadable Presettable Binary Up-Counter

This block is a synchronous binary up-counter assembled from identical 4-bit slices. Each slice can be cleared to zero, loaded from a parallel data input, incremented, or held. A fixed priority decides between these on every rising clock edge: clear first, then load, then count. Clear and load are both active low and both synchronous, so nothing moves between edges.

Counting is gated by two active-high enables. The parallel enable is shared by every slice. The trailing enable also feeds forward, without a register, into the slice's terminal-count flag. That flag rises when the slice holds all ones and the trailing enable is high. The top level chains the slices: each flag drives the trailing enable of the next, more significant slice. The result is one wide counter with a combinational look-ahead carry-out. A modulo-M counter needs only an external decode of count M−1 wired onto the clear input. Because the clear is synchronous, the count then runs 0 to M−1 with no transient extra state.

Top module: `cc_chain_counter`

## Requirements
- R1: While `clr_n` is 0 at a rising edge, `count` becomes 0 after that edge, whatever `load_n`, `din`, `en_par` and `en_trail` are.
- R2: While `clr_n` is 1 and `load_n` is 0 at a rising edge, `count` takes the value of `din` after that edge, whatever the two enables are.
- R3: While `clr_n` and `load_n` are 1 and both `en_par` and `en_trail` are 1 at a rising edge, `count` increases by exactly one.
- R4: While `clr_n` and `load_n` are 1 and either enable is 0 at a rising edge, `count` keeps its value.
- R5: An increment from all ones wraps `count` to 0 on that edge.
- R6: `carry_out` is 1 exactly when `count` is all ones and `en_trail` is 1. It follows `en_trail` combinationally, with no clock edge needed. During an uninterrupted count it is high for exactly the one state at the maximum value. After a load or clear from that state, it reflects the new count.
- R7: Slice k's terminal-count flag is its trailing enable ANDed with its own bits all being one, and that flag is the trailing enable of slice k+1. As a result, `count` behaves as one `NUM_SLICES`×4-bit binary counter: a carry propagates across slice boundaries in a single edge, and a low `en_trail` freezes every slice.
- R8: With `clr_n` driven from a decode of `count` == M−1 and both enables high, `count` cycles 0, 1, …, M−1, 0 with no other value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all state |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| din | input | NUM_SLICES*SLICE_W | Parallel load data |
| en_par | input | 1 | Count enable shared by every slice |
| en_trail | input | 1 | Count enable of the least significant slice, fed forward to the carry |
| count | output | NUM_SLICES*SLICE_W | Current count |
| carry_out | output | 1 | Terminal-count flag of the most significant slice |

## Verification
A wrong internal count appears at `count` on the very next sample after the faulty edge, because every bit is a port. A wrong priority, such as a load overriding a clear or an enable wrongly ignored, shows up one edge after the offending input combination. A broken look-ahead path between slices shows up either as a missing carry into the upper nibble on the edge after a `0x0F` state, or as an upper nibble that moves while `en_trail` is low. A stuck or registered terminal flag shows up at `carry_out` within the same cycle, when `en_trail` is toggled while the count is at its maximum.

// File: rtl/cc_pkg.sv
// Shared types for the cascadable counter.
package cc_pkg;
    // Action a slice takes at the next rising edge, in priority order.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_COUNT = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } act_e;
endpackage

// File: rtl/cc_action_sel.sv
// Picks the slice action from the control inputs.
// Assumes clear outranks load, and load outranks count; purely combinational.
module cc_action_sel
    import cc_pkg::*;
(
    input  logic clr_n,
    input  logic load_n,
    input  logic en_par,
    input  logic en_trail,
    output act_e act
);
    // Fixed priority: clear, then load, then count, else hold.
    always_comb begin
        if (!clr_n)
            act = ACT_CLEAR;
        else if (!load_n)
            act = ACT_LOAD;
        else if (en_par && en_trail)
            act = ACT_COUNT;
        else
            act = ACT_HOLD;
    end
endmodule

// File: rtl/cc_term_detect.sv
// Look-ahead terminal-count flag for one slice.
// Assumes the trailing enable is fed forward with no register in the path.
module cc_term_detect #(
    parameter int W = 4
) (
    input  logic [W-1:0] q,
    input  logic         en_trail,
    output logic         tc
);
    // High when the slice is full and its trailing enable is high.
    assign tc = en_trail & (&q);
endmodule

// File: rtl/cc_slice.sv
// One counter slice: register, priority action and terminal flag.
// Assumes clr_n doubles as the synchronous reset of the slice.
module cc_slice
    import cc_pkg::*;
#(
    parameter int SLICE_W = 4
) (
    input  logic               clk,
    input  logic               clr_n,
    input  logic               load_n,
    input  logic [SLICE_W-1:0] din,
    input  logic               en_par,
    input  logic               en_trail,
    output logic [SLICE_W-1:0] q,
    output logic               tc
);
    act_e act;

    cc_action_sel u_sel (
        .clr_n    (clr_n),
        .load_n   (load_n),
        .en_par   (en_par),
        .en_trail (en_trail),
        .act      (act)
    );

    cc_term_detect #(.W(SLICE_W)) u_tc (
        .q        (q),
        .en_trail (en_trail),
        .tc       (tc)
    );

    // Count register: applies the chosen action on each rising edge.
    always_ff @(posedge clk) begin
        case (act)
            ACT_CLEAR: q <= '0;
            ACT_LOAD:  q <= din;
            ACT_COUNT: q <= q + 1'b1;
            default:   q <= q;
        endcase
    end

    // Clear is the reset itself, so this one is not disabled by it.
    AST_CLR_ZERO: assert property (@(posedge clk)
        !clr_n |=> (q == '0));                                              // R1
    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> (q == $past(din)));                                     // R2
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && en_trail) |=> (q == SLICE_W'($past(q) + 1'b1))); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_par && en_trail)) |=> $stable(q));                  // R4
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && en_trail && (&q)) |=> (q == '0));              // R5
    AST_TC_NEEDS_FULL: assert property (@(posedge clk) disable iff (!clr_n)
        tc |-> ((&q) && en_trail));                                         // R6
endmodule

// File: rtl/cc_chain_counter.sv
// Wide counter built by chaining NUM_SLICES look-ahead slices.
// Assumes en_par is shared and each slice's flag feeds the next slice's
// trailing enable; carry_out is the flag of the top slice.
module cc_chain_counter #(
    parameter int SLICE_W    = 4,
    parameter int NUM_SLICES = 2
) (
    input  logic                          clk,
    input  logic                          clr_n,
    input  logic                          load_n,
    input  logic [NUM_SLICES*SLICE_W-1:0] din,
    input  logic                          en_par,
    input  logic                          en_trail,
    output logic [NUM_SLICES*SLICE_W-1:0] count,
    output logic                          carry_out
);
    localparam int TOTAL_W = NUM_SLICES * SLICE_W;

    logic [NUM_SLICES:0] trail;

    // The first slice sees the external trailing enable.
    assign trail[0] = en_trail;

    // One slice per nibble; each flag enables the next slice up.
    for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
        cc_slice #(.SLICE_W(SLICE_W)) u_slice (
            .clk      (clk),
            .clr_n    (clr_n),
            .load_n   (load_n),
            .din      (din[k*SLICE_W +: SLICE_W]),
            .en_par   (en_par),
            .en_trail (trail[k]),
            .q        (count[k*SLICE_W +: SLICE_W]),
            .tc       (trail[k+1])
        );
    end

    // Overall carry comes from the most significant slice.
    assign carry_out = trail[NUM_SLICES];

    AST_WIDE_STEP: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && en_trail) |=> (count == TOTAL_W'($past(count) + 1'b1))); // R7
    AST_WIDE_FREEZE: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !en_trail) |=> $stable(count));                                  // R7
    AST_CARRY_FULL: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out |-> ((&count) && en_trail));                                       // R6
endmodule

// File: tb/tb_cc_chain_counter.sv
`timescale 1ns/1ps
// Bench: behavioural integer model, compared after every clock edge.
module tb_cc_chain_counter;
    localparam int SW = 4;
    localparam int NS = 2;
    localparam int TW = SW * NS;
    localparam int MAXV = (1 << TW) - 1;

    logic          clk = 1'b0;
    logic          clr_n = 1'b0;
    logic          load_n = 1'b1;
    logic [TW-1:0] din = '0;
    logic          en_par = 1'b0;
    logic          en_trail = 1'b0;
    logic [TW-1:0] count;
    logic          carry_out;

    int n_chk = 0;
    int n_bad = 0;
    int model = 0;

    cc_chain_counter #(.SLICE_W(SW), .NUM_SLICES(NS)) dut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
        .en_par(en_par), .en_trail(en_trail),
        .count(count), .carry_out(carry_out)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Apply one set of inputs after a falling edge, check the flag, clock it,
    // and check the count at the next falling edge.
    task automatic apply(input logic c, input logic l, input int d,
                         input logic ep, input logic et, input string tag);
        clr_n = c; load_n = l; din = TW'(d); en_par = ep; en_trail = et;
        #1;
        check({tag, " R6 carry"}, int'(carry_out), int'(model == MAXV && et));
        if (!c)            model = 0;
        else if (!l)       model = d & MAXV;
        else if (ep && et) model = (model + 1) & MAXV;
        @(posedge clk);
        @(negedge clk);
        check({tag, " count"}, int'(count), model);
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        apply(0, 1, 0, 1, 1, "R1 reset");
        apply(1, 0, 'hA5, 0, 0, "R2 load enables low");
        apply(0, 0, 'h3C, 1, 1, "R1 clear beats load");
        apply(1, 0, 'h7E, 1, 1, "R2 load beats count");
        apply(1, 1, 0, 1, 1, "R3 step");
        apply(1, 1, 0, 1, 1, "R7 carry into upper slice");
        apply(1, 1, 0, 0, 1, "R4 hold en_par low");
        apply(1, 1, 0, 1, 0, "R4 hold en_trail low");
        apply(1, 1, 0, 0, 0, "R4 hold both low");
        apply(1, 0, 'h0F, 0, 0, "R2 load 0F");
        apply(1, 1, 0, 1, 0, "R7 en_trail low freezes upper");
        apply(1, 1, 0, 1, 1, "R7 0F to 10");
        apply(1, 0, 'hFF, 0, 0, "R2 load FF");
        // Flag must follow en_trail without any edge.
        en_trail = 1'b1; #1;
        check("R6 flag rises without edge", int'(carry_out), 1);
        en_trail = 1'b0; #1;
        check("R6 flag falls without edge", int'(carry_out), 0);
        @(negedge clk);
        apply(1, 0, 'h12, 1, 1, "R6 load from full");
        apply(1, 0, 'hFE, 0, 0, "R2 load FE");
        apply(1, 1, 0, 1, 1, "R6 reach full");
        apply(1, 1, 0, 1, 1, "R5 wrap");
        apply(1, 1, 0, 1, 1, "R6 pulse ends");
        apply(1, 0, 'hFF, 0, 0, "R2 load FF again");
        apply(0, 1, 0, 1, 1, "R1 clear from full");
        // Modulo-10 via decode of 9 onto clear.
        for (int i = 0; i < 25; i++) begin
            apply(model != 9, 1, 0, 1, 1, "R8 mod ten");
            check("R8 in range", int'(count < 10), 1);
        end
        // Mixed stimulus against the model.
        for (int i = 0; i < 600; i++) begin
            logic [4:0] r;
            r = 5'($urandom);
            apply(r[4] | r[3], ~(r[2] & r[1]), int'($urandom) & MAXV,
                  r[0] | r[1], r[0] | r[3], "R3 mixed");
        end
        // Long free run across every value.
        apply(0, 1, 0, 1, 1, "R1 clear before run");
        for (int i = 0; i < 260; i++)
            apply(1, 1, 0, 1, 1, "R7 full run");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule